// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

This block is a 16-bit up-counter for a microcontroller-class chip. It has two count sources. In timer mode it advances once per machine cycle, where one machine cycle is two clock cycles. In pin mode it advances once for every high-to-low transition seen on an external count pin. The count pin is sampled once per machine cycle.

A second external pin, the trigger pin, has its own falling-edge sampler. A trigger edge either copies the live count into a 16-bit holding register (capture mode) or loads the count from that register (reload mode). The holding register also supplies the restart value when the counter wraps in reload mode. Each wrap sets a sticky overflow flag and can invert a toggle output. Each trigger edge sets a separate sticky trigger flag.

Two write strobes let the surrounding register decoder preset the count and the holding register. A run enable gates counting. The pin samplers keep tracking the pin levels while counting is stopped.

Top module: `capreload_timer`

## Requirements
- R1: After reset the count, the holding register, both flags and the toggle output are all 0.
- R2: In timer mode (`src_sel`=0) with `run_en` high, the count rises by exactly N over any 2N consecutive clock cycles.
- R3: In pin mode (`src_sel`=1) with `run_en` high, the count rises by one for each 1-to-0 change of `cnt_pin`, where each pin level is held for at least two machine cycles. A level held steady, low or high, adds nothing.
- R4: While `run_en` is low the count holds its value. A fall of `cnt_pin` that happens while stopped is not counted when `run_en` returns high.
- R5: With `trig_mode`=0, an increment from 0xFFFF gives 0x0000 and sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed.
- R6: With `trig_mode`=1, an increment from 0xFFFF loads the holding register value into the count and sets `ovf_flag`.
- R7: With `trig_mode`=0, a fall of `trig_pin` copies the count into `cap_val` and leaves the count unchanged. This holds whether or not `run_en` is high.
- R8: With `trig_mode`=1, a fall of `trig_pin` loads the count from `cap_val`. This holds whether or not `run_en` is high.
- R9: Every fall of `trig_pin` sets `ext_flag`. It is sticky and distinct from `ovf_flag`.
- R10: `ovf_clr` clears only `ovf_flag`, and `ext_clr` clears only `ext_flag`. A set event in the same cycle wins over a clear.
- R11: `tog_out` inverts on each overflow when `toggle_en` is high. It holds when `toggle_en` is low.
- R12: `load_cnt` writes `load_data` into the count, and `load_cap` writes it into `cap_val`. Each write is visible after one clock edge and takes priority over count and trigger events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counting enable |
| src_sel | input | 1 | 0: machine-cycle tick, 1: count pin falls |
| trig_mode | input | 1 | 0: capture, 1: reload |
| toggle_en | input | 1 | Enables toggle output on overflow |
| cnt_pin | input | 1 | External count pin |
| trig_pin | input | 1 | External capture/reload trigger pin |
| ovf_clr | input | 1 | Clears overflow flag |
| ext_clr | input | 1 | Clears trigger flag |
| load_cnt | input | 1 | Write strobe for the count |
| load_cap | input | 1 | Write strobe for the holding register |
| load_data | input | 16 | Write data for both strobes |
| count | output | 16 | Current count |
| cap_val | output | 16 | Capture/reload holding register |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky trigger flag |
| tog_out | output | 1 | Overflow toggle output |

## Verification
A pin fall reaches the count, the holding register, the flags and `tog_out` at the same clock edge on which the machine-cycle sample sees the low level. A load strobe takes effect at the next edge. Because the machine-cycle phase is not visible at the ports, the bench holds every pin level for four clocks, which is exactly two samples. It then checks only after the whole pulse has passed, and runs timer mode for an even number of clocks, so the expected change does not depend on the phase. All inputs are driven and all outputs are sampled on the falling clock edge.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  typedef enum logic {
    SRC_MCYCLE = 1'b0,
    SRC_PIN    = 1'b1
  } tcr_src_e;

  typedef enum logic {
    TRG_CAPTURE = 1'b0,
    TRG_RELOAD  = 1'b1
  } tcr_trg_e;
endpackage

// File: rtl/mc_tick_gen.sv
// Machine-cycle strobe: one clock wide, once every CLK_PER_MC clocks.
module mc_tick_gen #(
  parameter int CLK_PER_MC = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CLK_PER_MC <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(CLK_PER_MC);
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_MC - 1);
      logic [PW-1:0] ph_q, ph_d;

      always_comb begin
        if (ph_q == LAST) ph_d = '0;
        else              ph_d = ph_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
      end

      assign tick = (ph_q == LAST);

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/fall_sampler.sv
// Samples a pin once per machine cycle. Reports a fall when the previous sample
// was high and the current one is low. History is kept whether or not counting runs.
module fall_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic last_q, last_d;

  always_comb begin
    last_d = last_q;
    if (tick) last_d = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= last_d;
  end

  assign fall = tick & last_q & ~pin;

  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tcr_core.sv
// Count register, holding register, sticky flags and toggle output.
module tcr_core
  import tcr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run_en,
  input  tcr_src_e     src,
  input  tcr_trg_e     trg_mode,
  input  logic         toggle_en,
  input  logic         cnt_fall,
  input  logic         trg_fall,
  input  logic         ovf_clr,
  input  logic         ext_clr,
  input  logic         load_cnt,
  input  logic         load_cap,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cap_q,
  output logic         ovf_q,
  output logic         ext_q,
  output logic         tog_q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] cnt_d, cap_d;
  logic         ovf_d, ext_d, tog_d;
  logic         inc_evt, at_max, ovf_evt, trg_cap, trg_rld;

  always_comb begin
    inc_evt = run_en & ((src == SRC_PIN) ? cnt_fall : tick);
    at_max  = (cnt_q == ALL_ONES);
    trg_cap = trg_fall & (trg_mode == TRG_CAPTURE);
    trg_rld = trg_fall & (trg_mode == TRG_RELOAD);
    ovf_evt = inc_evt & at_max & ~load_cnt & ~trg_rld;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_cnt)     cnt_d = load_data;
    else if (trg_rld) cnt_d = cap_q;
    else if (ovf_evt) cnt_d = (trg_mode == TRG_RELOAD) ? cap_q : '0;
    else if (inc_evt) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    cap_d = cap_q;
    if (load_cap)     cap_d = load_data;
    else if (trg_cap) cap_d = cnt_q;
  end

  always_comb begin
    ovf_d = ovf_evt  | (ovf_q & ~ovf_clr);
    ext_d = trg_fall | (ext_q & ~ext_clr);
    tog_d = tog_q ^ (ovf_evt & toggle_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      ovf_q <= ovf_d;
      ext_q <= ext_d;
      tog_q <= tog_d;
    end
  end

  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_cnt && !trg_fall) |=> $stable(cnt_q));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && src == SRC_MCYCLE && tick && !load_cnt && !trg_fall && cnt_q != ALL_ONES)
      |=> cnt_q == $past(cnt_q) + 1'b1);

  // R7
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_fall && trg_mode == TRG_CAPTURE && !load_cap) |=> cap_q == $past(cnt_q));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R9
  ext_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && !ext_clr) |=> ext_q);

  // R11
  toggle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle_en |=> $stable(tog_q));
endmodule

// File: rtl/capreload_timer.sv
module capreload_timer
  import tcr_pkg::*;
#(
  parameter int W          = 16,
  parameter int CLK_PER_MC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         src_sel,
  input  logic         trig_mode,
  input  logic         toggle_en,
  input  logic         cnt_pin,
  input  logic         trig_pin,
  input  logic         ovf_clr,
  input  logic         ext_clr,
  input  logic         load_cnt,
  input  logic         load_cap,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic         ovf_flag,
  output logic         ext_flag,
  output logic         tog_out
);
  localparam int NPIN = 2;

  logic            tick;
  logic [NPIN-1:0] pins, falls;

  assign pins = {trig_pin, cnt_pin};

  mc_tick_gen #(.CLK_PER_MC(CLK_PER_MC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      fall_sampler u_smp (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .pin  (pins[i]),
        .fall (falls[i])
      );
    end
  endgenerate

  tcr_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run_en   (run_en),
    .src      (tcr_src_e'(src_sel)),
    .trg_mode (tcr_trg_e'(trig_mode)),
    .toggle_en(toggle_en),
    .cnt_fall (falls[0]),
    .trg_fall (falls[1]),
    .ovf_clr  (ovf_clr),
    .ext_clr  (ext_clr),
    .load_cnt (load_cnt),
    .load_cap (load_cap),
    .load_data(load_data),
    .cnt_q    (count),
    .cap_q    (cap_val),
    .ovf_q    (ovf_flag),
    .ext_q    (ext_flag),
    .tog_q    (tog_out)
  );
endmodule

// File: tb/capreload_timer_test.sv
`timescale 1ns/1ps
module capreload_timer_test;
  logic clk = 1'b0;
  logic rst_n, run_en, src_sel, trig_mode, toggle_en, cnt_pin, trig_pin;
  logic ovf_clr, ext_clr, load_cnt, load_cap;
  logic [15:0] load_data, count, cap_val;
  logic ovf_flag, ext_flag, tog_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic exp_tog = 1'b0;

  always #4 clk = ~clk;

  capreload_timer uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
    .trig_mode(trig_mode), .toggle_en(toggle_en), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .ovf_clr(ovf_clr), .ext_clr(ext_clr),
    .load_cnt(load_cnt), .load_cap(load_cap), .load_data(load_data),
    .count(count), .cap_val(cap_val), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .tog_out(tog_out)
  );

  typedef struct packed {
    logic        src;
    logic        rel;
    logic [15:0] cap;
    logic [15:0] start;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 8'd5, 16'h0005, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 16'hFFFE, 8'd3, 16'h0001, 1'b1},
    '{1'b1, 1'b0, 16'h0000, 16'h0010, 8'd4, 16'h0014, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 16'hFFFF, 8'd2, 16'h0001, 1'b1},
    '{1'b0, 1'b1, 16'h8000, 16'hFFFF, 8'd2, 16'h8001, 1'b1},
    '{1'b1, 1'b1, 16'h1234, 16'hFFFE, 8'd3, 16'h1235, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_cnt(input logic [15:0] v);
    load_data = v; load_cnt = 1'b1; step(1); load_cnt = 1'b0;
  endtask

  task automatic put_cap(input logic [15:0] v);
    load_data = v; load_cap = 1'b1; step(1); load_cap = 1'b0;
  endtask

  task automatic clear_flags();
    ovf_clr = 1'b1; ext_clr = 1'b1; step(1); ovf_clr = 1'b0; ext_clr = 1'b0;
  endtask

  task automatic pulse_cnt();
    cnt_pin = 1'b0; step(4); cnt_pin = 1'b1; step(4);
  endtask

  task automatic pulse_trig();
    trig_pin = 1'b0; step(4); trig_pin = 1'b1; step(4);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; src_sel = 1'b0; trig_mode = 1'b0; toggle_en = 1'b1;
    cnt_pin = 1'b1; trig_pin = 1'b1; ovf_clr = 1'b0; ext_clr = 1'b0;
    load_cnt = 1'b0; load_cap = 1'b0; load_data = '0;
    step(3);
    // R1 reset state
    check("R1 count", count, 16'h0);
    check("R1 cap", cap_val, 16'h0);
    check("R1 flags/tog", {13'h0, ovf_flag, ext_flag, tog_out}, 16'h0);
    rst_n = 1'b1;
    step(2);

    // R12 loads
    put_cnt(16'h00A5);
    check("R12 load count", count, 16'h00A5);
    put_cap(16'h5A00);
    check("R12 load cap", cap_val, 16'h5A00);

    // Table: R2 R3 R5 R6 R11
    foreach (VECS[i]) begin
      src_sel = VECS[i].src; trig_mode = VECS[i].rel;
      put_cap(VECS[i].cap);
      put_cnt(VECS[i].start);
      clear_flags();
      run_en = 1'b1;
      if (VECS[i].src) begin
        for (int k = 0; k < int'(VECS[i].n); k++) pulse_cnt();
      end else begin
        step(2 * int'(VECS[i].n));
      end
      run_en = 1'b0;
      step(1);
      if (VECS[i].exp_ovf) exp_tog = ~exp_tog;
      check(VECS[i].rel ? "R6 count" : (VECS[i].src ? "R3 count" : "R2 count"),
            count, VECS[i].exp_cnt);
      check("R5 ovf_flag", {15'h0, ovf_flag}, {15'h0, VECS[i].exp_ovf});
      check("R11 tog_out", {15'h0, tog_out}, {15'h0, exp_tog});
    end

    // R4: stopped hold, and a fall while stopped is not counted later
    src_sel = 1'b1; trig_mode = 1'b0;
    put_cnt(16'h0100);
    pulse_cnt();
    check("R4 hold while stopped", count, 16'h0100);
    cnt_pin = 1'b0; step(6);
    run_en = 1'b1; step(8);
    check("R4 no false edge on resume", count, 16'h0100);
    // R3: steady high level adds nothing, then a real fall counts
    cnt_pin = 1'b1; step(16);
    check("R3 steady high", count, 16'h0100);
    pulse_cnt();
    check("R3 fall counted", count, 16'h0101);
    run_en = 1'b0;

    // R7 capture, R9 flag
    clear_flags();
    put_cnt(16'h1234);
    pulse_trig();
    check("R7 capture value", cap_val, 16'h1234);
    check("R7 count untouched", count, 16'h1234);
    check("R9 ext_flag set", {15'h0, ext_flag}, 16'h1);
    check("R9 ovf separate", {15'h0, ovf_flag}, 16'h0);

    // R8 reload from trigger
    trig_mode = 1'b1;
    put_cap(16'hABCD);
    put_cnt(16'h0005);
    pulse_trig();
    check("R8 reload value", count, 16'hABCD);

    // R10 independent clears
    trig_mode = 1'b0; src_sel = 1'b0;
    put_cnt(16'hFFFF);
    run_en = 1'b1; step(2); run_en = 1'b0; step(1);
    exp_tog = ~exp_tog;
    check("R10 both set", {14'h0, ovf_flag, ext_flag}, 16'h3);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    check("R10 ovf_clr only", {14'h0, ovf_flag, ext_flag}, 16'h1);
    ext_clr = 1'b1; step(1); ext_clr = 1'b0;
    check("R10 ext_clr", {14'h0, ovf_flag, ext_flag}, 16'h0);

    // R11 toggle disabled
    toggle_en = 1'b0;
    put_cnt(16'hFFFF);
    run_en = 1'b1; step(2); run_en = 1'b0; step(1);
    check("R11 ovf without toggle", {15'h0, ovf_flag}, 16'h1);
    check("R11 tog held", {15'h0, tog_out}, {15'h0, exp_tog});

    finish_run();
  end
endmodule